// File: doc/BRIEF.md
# Instruction Decoder and Next-PC Unit

This block sits at the decode point of a small load/store processor with sixteen-bit instruction words. From one instruction word it produces the control signals for the rest of the machine: the two source register indices, the destination index, a sign-extended offset, an ALU operation code, the register-write enable and the memory read and write enables. It also produces the address of the next instruction. The address is either the following word, a branch target chosen by comparing the two register values the caller supplies, or an absolute jump target.

All outputs are registered once, so the decode of the word presented before a rising clock edge is visible just after that edge. A synchronous active-low reset clears every output to zero. The block also gives the word index of the next instruction, because the instruction store holds one word for every two bytes of program counter. The register file, ALU, memories and fetch logic are outside this block.

Top module: `instr_dec_npc`

## Requirements
- R1: The opcode is instr[15:12]. Opcodes 0010 add, 0011 sub, 0100 invert, 0101 shift-left, 0110 shift-right, 0111 and, 1000 or and 1001 set-less-than assert reg_we and select rd_idx = instr[5:3]. They drive alu_op as 0, 1, 2, 3, 4, 5, 6 and 7 respectively, and assert neither memory enable.
- R2: rs1_idx is always instr[11:9] and rs2_idx is always instr[8:6].
- R3: Load (0000) asserts reg_we and mem_re, not mem_we. It sets rd_idx = instr[8:6] and alu_op = 0 (add, for base plus offset).
- R4: Store (0001) asserts mem_we only, with alu_op = 0. The data register is rs2_idx.
- R5: imm is instr[5:0] sign-extended to 16 bits, for every opcode.
- R6: BEQ (1011) gives next_pc = pc + 2 + (imm << 1) when rs1_val equals rs2_val, and pc + 2 otherwise. Neither write enable is asserted and alu_op = 1.
- R7: BNE (1100) takes the same target when rs1_val differs from rs2_val, and gives pc + 2 otherwise. Neither write enable is asserted.
- R8: Jump (1101) gives next_pc = {3'b000, instr[11:0], 1'b0}, so an all-zero field jumps to address 0. No enable is asserted.
- R9: Every other opcode gives next_pc = pc + 2, wrapping modulo 2^16.
- R10: The undefined opcodes 1010, 1110 and 1111 assert no register write, memory read or memory write, and give alu_op = 0.
- R11: mem_re and mem_we are never asserted together.
- R12: Outputs change one clock edge after the inputs are sampled. A rising edge with rst_n low sets every output to zero.
- R13: word_idx equals next_pc[4:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word to decode |
| pc | input | 16 | Byte address of that instruction |
| rs1_val | input | 16 | Value of register rs1_idx, for branch compare |
| rs2_val | input | 16 | Value of register rs2_idx, for branch compare |
| rs1_idx | output | 3 | First source / base register index |
| rs2_idx | output | 3 | Second source / store data register index |
| rd_idx | output | 3 | Destination register index |
| imm | output | 16 | Sign-extended offset |
| alu_op | output | 3 | ALU operation code |
| reg_we | output | 1 | Register write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| next_pc | output | 16 | Address of the next instruction |
| word_idx | output | 4 | Instruction word index of next_pc |

## Verification
The only state is the single output register stage. A wrong opcode decode or branch choice therefore shows on the ports one edge after the offending word is presented, and no later. A misrouted field shows as a wrong index or enable on that same edge. A wrong comparison or sign extension shows as a next_pc that differs from pc + 2 by the wrong amount. The tests drive each opcode class, both outcomes of each branch, positive and negative offsets, the jump extremes, wrap at the top of the address space and a reset in the middle of a run.

// File: rtl/dec_pkg.sv
// Package: shared encodings for the instruction decoder.
// Assumes a 4-bit opcode in the top bits of the instruction word.
package dec_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LD  = 4'h0;
    localparam logic [OPC_W-1:0] OPC_ST  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'h2;
    localparam logic [OPC_W-1:0] OPC_SUB = 4'h3;
    localparam logic [OPC_W-1:0] OPC_INV = 4'h4;
    localparam logic [OPC_W-1:0] OPC_SHL = 4'h5;
    localparam logic [OPC_W-1:0] OPC_SHR = 4'h6;
    localparam logic [OPC_W-1:0] OPC_AND = 4'h7;
    localparam logic [OPC_W-1:0] OPC_OR  = 4'h8;
    localparam logic [OPC_W-1:0] OPC_SLT = 4'h9;
    localparam logic [OPC_W-1:0] OPC_BEQ = 4'hB;
    localparam logic [OPC_W-1:0] OPC_BNE = 4'hC;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'hD;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_INV = 3'd2,
        ALU_SHL = 3'd3,
        ALU_SHR = 3'd4,
        ALU_AND = 3'd5,
        ALU_OR  = 3'd6,
        ALU_SLT = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    mem_re;
        logic    mem_we;
        logic    rd_mid;   // destination taken from the middle register field
        alu_op_e alu;
        logic    br_eq;
        logic    br_ne;
        logic    jmp;
    } ctrl_t;

endpackage

// File: rtl/dec_fields.sv
// Module: dec_fields
// Splits an instruction word into opcode, three register fields, a
// sign-extended offset and a jump target field.
// Assumes the opcode sits in the top OPC_W bits and the offset in the low bits.
module dec_fields
    import dec_pkg::*;
#(
    parameter int XLEN   = 16,
    parameter int REG_AW = 3,
    parameter int OFF_W  = 6
) (
    input  logic [XLEN-1:0]       instr,
    output logic [OPC_W-1:0]      opc,
    output logic [REG_AW-1:0]     fld_a,
    output logic [REG_AW-1:0]     fld_b,
    output logic [REG_AW-1:0]     fld_c,
    output logic [XLEN-1:0]       imm_sx,
    output logic [XLEN-OPC_W-1:0] jtgt
);
    localparam int A_HI = XLEN - OPC_W - 1;
    localparam int B_HI = A_HI - REG_AW;
    localparam int C_HI = B_HI - REG_AW;

    logic [OFF_W-1:0] off_raw;

    // Field extraction and sign extension of the offset.
    always_comb begin
        opc     = instr[XLEN-1 -: OPC_W];
        fld_a   = instr[A_HI -: REG_AW];
        fld_b   = instr[B_HI -: REG_AW];
        fld_c   = instr[C_HI -: REG_AW];
        off_raw = instr[OFF_W-1:0];
        imm_sx  = {{(XLEN-OFF_W){off_raw[OFF_W-1]}}, off_raw};
        jtgt    = instr[XLEN-OPC_W-1:0];
    end
endmodule

// File: rtl/dec_ctrl.sv
// Module: dec_ctrl
// Maps an opcode to the control bundle. Any opcode not listed decodes
// to a no-op: no writes, add on the ALU, sequential next PC.
module dec_ctrl
    import dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ctrl_t            ctrl
);
    // Opcode lookup with a quiet default.
    always_comb begin
        ctrl = '{reg_we: 1'b0, mem_re: 1'b0, mem_we: 1'b0, rd_mid: 1'b0,
                 alu: ALU_ADD, br_eq: 1'b0, br_ne: 1'b0, jmp: 1'b0};
        unique case (opc)
            OPC_LD:  begin ctrl.reg_we = 1'b1; ctrl.mem_re = 1'b1; ctrl.rd_mid = 1'b1; end
            OPC_ST:  ctrl.mem_we = 1'b1;
            OPC_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_ADD; end
            OPC_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SUB; end
            OPC_INV: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_INV; end
            OPC_SHL: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SHL; end
            OPC_SHR: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SHR; end
            OPC_AND: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_AND; end
            OPC_OR:  begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_OR;  end
            OPC_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
            OPC_BEQ: begin ctrl.br_eq = 1'b1; ctrl.alu = ALU_SUB; end
            OPC_BNE: begin ctrl.br_ne = 1'b1; ctrl.alu = ALU_SUB; end
            OPC_JMP: ctrl.jmp = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dec_npc.sv
// Module: dec_npc
// Chooses the next program counter: sequential, branch target or jump.
// Assumes byte addressing with two bytes per instruction; sums wrap.
module dec_npc #(
    parameter int XLEN = 16,
    parameter int JT_W = 12
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm_sx,
    input  logic [JT_W-1:0] jtgt,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic            br_eq,
    input  logic            br_ne,
    input  logic            jmp,
    output logic [XLEN-1:0] npc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(2);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;
    logic            same;
    logic            take;

    // Candidate addresses and branch decision, then the final select.
    always_comb begin
        seq_pc = pc + STEP;
        br_pc  = seq_pc + {imm_sx[XLEN-2:0], 1'b0};
        jmp_pc = {{(XLEN-JT_W-1){1'b0}}, jtgt, 1'b0};
        same   = (rs1_val == rs2_val);
        take   = (br_eq && same) || (br_ne && !same);
        if (jmp)       npc = jmp_pc;
        else if (take) npc = br_pc;
        else           npc = seq_pc;
    end
endmodule

// File: rtl/instr_dec_npc.sv
// Module: instr_dec_npc (top)
// Decodes one instruction per clock and registers the controls and next PC.
// Assumes rs1_val/rs2_val are the register values for rs1_idx/rs2_idx of the
// same word. Synchronous active-low reset clears every output.
module instr_dec_npc
    import dec_pkg::*;
#(
    parameter int XLEN   = 16,
    parameter int REG_AW = 3,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic [REG_AW-1:0] rs1_idx,
    output logic [REG_AW-1:0] rs2_idx,
    output logic [REG_AW-1:0] rd_idx,
    output logic [XLEN-1:0]   imm,
    output logic [2:0]        alu_op,
    output logic              reg_we,
    output logic              mem_re,
    output logic              mem_we,
    output logic [XLEN-1:0]   next_pc,
    output logic [IDX_W-1:0]  word_idx
);
    localparam int JT_W = XLEN - OPC_W;

    logic [OPC_W-1:0]  opc;
    logic [REG_AW-1:0] fa, fb, fc;
    logic [XLEN-1:0]   imm_sx;
    logic [JT_W-1:0]   jtgt;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   npc;

    dec_fields #(.XLEN(XLEN), .REG_AW(REG_AW), .OFF_W(OFF_W)) u_fields (
        .instr (instr),
        .opc   (opc),
        .fld_a (fa),
        .fld_b (fb),
        .fld_c (fc),
        .imm_sx(imm_sx),
        .jtgt  (jtgt)
    );

    dec_ctrl u_ctrl (
        .opc (opc),
        .ctrl(ctrl)
    );

    dec_npc #(.XLEN(XLEN), .JT_W(JT_W)) u_npc (
        .pc     (pc),
        .imm_sx (imm_sx),
        .jtgt   (jtgt),
        .rs1_val(rs1_val),
        .rs2_val(rs2_val),
        .br_eq  (ctrl.br_eq),
        .br_ne  (ctrl.br_ne),
        .jmp    (ctrl.jmp),
        .npc    (npc)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs1_idx <= '0;
            rs2_idx <= '0;
            rd_idx  <= '0;
            imm     <= '0;
            alu_op  <= '0;
            reg_we  <= 1'b0;
            mem_re  <= 1'b0;
            mem_we  <= 1'b0;
            next_pc <= '0;
        end else begin
            rs1_idx <= fa;
            rs2_idx <= fb;
            rd_idx  <= ctrl.rd_mid ? fb : fc;
            imm     <= imm_sx;
            alu_op  <= ctrl.alu;
            reg_we  <= ctrl.reg_we;
            mem_re  <= ctrl.mem_re;
            mem_we  <= ctrl.mem_we;
            next_pc <= npc;
        end
    end

    // Word index of the registered next address.
    always_comb word_idx = next_pc[IDX_W:1];

    // R11: the two memory enables never coincide.
    a_r11_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R10: an undefined opcode leaves no write and steps sequentially.
    a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(instr[XLEN-1 -: OPC_W]) inside {4'hA, 4'hE, 4'hF}))
        |-> (!reg_we && !mem_re && !mem_we && next_pc == $past(pc) + XLEN'(2)));

    // R7: BNE with equal operands falls through.
    a_r7_bne_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[XLEN-1 -: OPC_W]) == OPC_BNE
         && $past(rs1_val) == $past(rs2_val))
        |-> (next_pc == $past(pc) + XLEN'(2)));

    // R8: a jump lands in the low part of the address space.
    a_r8_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[XLEN-1 -: OPC_W]) == OPC_JMP)
        |-> (next_pc[XLEN-1 -: OPC_W-1] == '0 && !reg_we && !mem_we));

    // R9: an even PC never produces an odd next address.
    a_r9_even_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pc[0])) |-> !next_pc[0]);

    // R12: the first edge after reset is released still shows reset values.
    a_r12_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!reg_we && !mem_re && !mem_we && next_pc == '0));
endmodule

// File: tb/instr_dec_npc_test.sv
module instr_dec_npc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h2000;
    logic [15:0] pc = 16'h0;
    logic [15:0] rs1_val = 16'h0;
    logic [15:0] rs2_val = 16'h0;
    logic [2:0]  rs1_idx, rs2_idx, rd_idx, alu_op;
    logic [15:0] imm, next_pc;
    logic        reg_we, mem_re, mem_we;
    logic [3:0]  word_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    instr_dec_npc uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
        .rs1_val(rs1_val), .rs2_val(rs2_val),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx), .imm(imm),
        .alu_op(alu_op), .reg_we(reg_we), .mem_re(mem_re), .mem_we(mem_we),
        .next_pc(next_pc), .word_idx(word_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one word, let one edge register it, sample 2 ns later.
    task automatic apply(input logic [15:0] i, input logic [15:0] p,
                         input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        instr = i; pc = p; rs1_val = a; rs2_val = b;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] w(input logic [3:0] op, input logic [2:0] ra,
                                      input logic [2:0] rb, input logic [5:0] lo);
        return {op, ra, rb, lo};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        apply(16'h2FFF, 16'h1234, 0, 0);
        chk("R12 reset reg_we", reg_we, 0);
        chk("R12 reset next_pc", next_pc, 0);
        chk("R12 reset imm", imm, 0);
        chk("R12 reset rd_idx", rd_idx, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_alu();
        for (int k = 0; k < 8; k++) begin
            apply(w(4'(k + 2), 3'd5, 3'd2, {3'd6, 3'd1}), 16'h0100, 1, 2);
            chk("R1 alu_op", alu_op, k);
            chk("R1 reg_we", reg_we, 1);
            chk("R1 rd_idx", rd_idx, 6);
            chk("R1 mem enables", {mem_re, mem_we}, 0);
            chk("R2 rs1_idx", rs1_idx, 5);
            chk("R2 rs2_idx", rs2_idx, 2);
            chk("R9 seq next_pc", next_pc, 16'h0102);
        end
    endtask

    task automatic t_load();
        apply(w(4'h0, 3'd2, 3'd4, 6'b000011), 16'h0020, 0, 0);
        chk("R3 load we/re/we", {reg_we, mem_re, mem_we}, 3'b110);
        chk("R3 load rd_idx", rd_idx, 4);
        chk("R3 load alu_op", alu_op, 0);
        chk("R5 positive imm", imm, 16'h0003);
    endtask

    task automatic t_store();
        apply(w(4'h1, 3'd1, 3'd7, 6'b100000), 16'h0040, 0, 0);
        chk("R4 store we/re/we", {reg_we, mem_re, mem_we}, 3'b001);
        chk("R4 store data reg", rs2_idx, 7);
        chk("R4 store alu_op", alu_op, 0);
        chk("R5 negative imm", imm, 16'hFFE0);
    endtask

    task automatic t_beq();
        apply(w(4'hB, 3'd0, 3'd1, 6'd1), 16'h0018, 16'h55, 16'h55);
        chk("R6 beq taken", next_pc, 16'h001C);
        chk("R6 beq no writes", {reg_we, mem_re, mem_we}, 0);
        chk("R6 beq alu_op", alu_op, 1);
        apply(w(4'hB, 3'd0, 3'd1, 6'b111110), 16'h0040, 16'h7, 16'h7);
        chk("R6 beq backward", next_pc, 16'h003E);
        apply(w(4'hB, 3'd0, 3'd1, 6'd1), 16'h0018, 16'h55, 16'h56);
        chk("R6 beq not taken", next_pc, 16'h001A);
    endtask

    task automatic t_bne();
        apply(w(4'hC, 3'd0, 3'd1, 6'd0), 16'h0018, 16'h1, 16'h2);
        chk("R7 bne taken zero offset", next_pc, 16'h001A);
        apply(w(4'hC, 3'd0, 3'd1, 6'd5), 16'h0030, 16'h1, 16'h2);
        chk("R7 bne taken", next_pc, 16'h003C);
        apply(w(4'hC, 3'd0, 3'd1, 6'd5), 16'h0030, 16'h9, 16'h9);
        chk("R7 bne not taken", next_pc, 16'h0032);
        chk("R7 bne no writes", {reg_we, mem_re, mem_we}, 0);
    endtask

    task automatic t_jump();
        apply(16'hD000, 16'h0ABC, 0, 0);
        chk("R8 jump to zero", next_pc, 16'h0000);
        chk("R8 jump no enables", {reg_we, mem_re, mem_we}, 0);
        apply(16'hDFFF, 16'h0002, 0, 0);
        chk("R8 jump max", next_pc, 16'h1FFE);
        apply(16'hD7FF, 16'hF000, 0, 0);
        chk("R8 jump high pc", next_pc, 16'h0FFE);
    endtask

    task automatic t_undef();
        logic [3:0] ops [3] = '{4'hA, 4'hE, 4'hF};
        for (int k = 0; k < 3; k++) begin
            apply({ops[k], 12'hFFF}, 16'h0060, 0, 0);
            chk("R10 undef no writes", {reg_we, mem_re, mem_we}, 0);
            chk("R10 undef alu_op", alu_op, 0);
            chk("R9 undef seq", next_pc, 16'h0062);
        end
    endtask

    task automatic t_wrap_idx();
        apply(w(4'h2, 0, 0, 0), 16'hFFFE, 0, 0);
        chk("R9 wrap", next_pc, 16'h0000);
        chk("R13 word_idx wrap", word_idx, 0);
        apply(w(4'h2, 0, 0, 0), 16'h0010, 0, 0);
        chk("R13 word_idx", word_idx, 9);
    endtask

    task automatic t_mid_reset();
        rst_n = 1'b0;
        apply(w(4'h0, 3'd1, 3'd2, 6'd3), 16'h0044, 0, 0);
        chk("R12 mid reset enables", {reg_we, mem_re, mem_we}, 0);
        chk("R12 mid reset next_pc", next_pc, 0);
        rst_n = 1'b1;
        apply(w(4'h0, 3'd1, 3'd2, 6'd3), 16'h0044, 0, 0);
        chk("R12 after reset", next_pc, 16'h0046);
        chk("R11 load not store", {mem_re, mem_we}, 2'b10);
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_alu();
        t_load();
        t_store();
        t_beq();
        t_bne();
        t_jump();
        t_undef();
        t_wrap_idx();
        t_mid_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule